// File: doc/BRIEF.md
# Keyboard Tone Generator with Band Select

This block is the core of a small electronic keyboard. Seven note keys pick one of seven scale notes. A separate band key steps through three octave bands: low, middle and high. Together they choose one of 21 pitches. The result is a 50% duty square wave on a buzzer pin.

All logic runs on one system clock, nominally 20 MHz. A one-in-`TICK_DIV` clock enable gives the tone reference, which is 5 MHz by default. Every key input passes through a two-flop synchronizer and a stable-level filter. The filter window is `DEB_TICKS` reference ticks, about 10 ms by default. A single shared half-period counter is reloaded from a computed table of divisors. It restarts whenever the band or note changes.

The block also presents the current band number and the active note number as 4-bit binary digits. External seven-segment decoders can display them directly.

`TONE_SHIFT` scales every divisor down by a power of two. This lets a small configuration keep the same table structure.

Top module: `tone_keyboard`

## Requirements
- R1: While reset is asserted and right after it is released, `band_code` is 1, `note_code` is 0 and `buzz` is 0.
- R2: `band_code` always reads 1 (low band), 2 (middle band) or 3 (high band) as a zero-extended 4-bit binary value.
- R3: Each filtered rising edge of `band_key` advances the band 1→2→3→1. Holding the key or releasing it has no further effect.
- R4: Any key level that lasts less than `DEB_TICKS` reference ticks is ignored, so neither the band nor the note display changes.
- R5: When exactly one note key is held, with bit i-1 of `note_keys` standing for note i, `note_code` shows i (1 to 7).
- R6: When no note key is held, or when more than one is held, `note_code` is 0 and `buzz` is held low.
- R7: For the selected tone with full-period divisor D, `buzz` stays high for exactly H = ((D >> TONE_SHIFT) >> 1) reference ticks, which is H·TICK_DIV clocks.
- R8: The low phase has the same length as the high phase. The divisors for notes 1..7 are 19080, 17006, 15150, 14326, 12756, 11360, 10120 in band 1; 9560, 8516, 7586, 7160, 6376, 5680, 5060 in band 2; and 4776, 4256, 3790, 3580, 3190, 2842, 2542 in band 3.
- R9: When the selected note or band changes, `buzz` is low one clock after `note_code` or `band_code` shows the new value. The new tone then runs with its own half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (20 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| note_keys | input | 7 | Raw note keys, active high; bit i-1 is note i |
| band_key | input | 1 | Raw band-select key, active high |
| buzz | output | 1 | Square-wave buzzer drive |
| band_code | output | 4 | Current band as a binary digit (1..3) |
| note_code | output | 4 | Active note as a binary digit (1..7), 0 when none or several |

## Verification
A band register that is corrupted or skips a step shows up on `band_code` at the next filtered press. An index into the divisor table that is off by one position appears within one tone period as a wrong high-phase or low-phase length, counted in clocks. A counter that fails to clear on a note change or on release shows up one clock later as a `buzz` level that is not low. A filter that is too short shows up as a short glitch that changes the displayed digits.

// File: rtl/tone_kbd_pkg.sv
package tone_kbd_pkg;

   localparam int NUM_BANDS = 3;
   localparam int NUM_NOTES = 7;

   // Full-period divisor, in reference ticks, for band 0..2 and note 0..6.
   function automatic int unsigned full_period(input int unsigned band, input int unsigned note);
      int unsigned idx;
      idx = band * NUM_NOTES + note;
      case (idx)
         0:  return 19080;
         1:  return 17006;
         2:  return 15150;
         3:  return 14326;
         4:  return 12756;
         5:  return 11360;
         6:  return 10120;
         7:  return 9560;
         8:  return 8516;
         9:  return 7586;
         10: return 7160;
         11: return 6376;
         12: return 5680;
         13: return 5060;
         14: return 4776;
         15: return 4256;
         16: return 3790;
         17: return 3580;
         18: return 3190;
         19: return 2842;
         default: return 2542;
      endcase
   endfunction

endpackage

// File: rtl/key_conditioner.sv
module key_conditioner #(
   parameter int NUM_KEYS  = 1,
   parameter int DEB_TICKS = 50000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic [NUM_KEYS-1:0] raw,
   output logic [NUM_KEYS-1:0] clean
);

   localparam int DW = $clog2(DEB_TICKS + 1);

   generate
      if (DEB_TICKS < 1) begin : g_bad_window
         $error("key_conditioner: DEB_TICKS must be at least 1");
      end

      for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
         logic [1:0]    sync_q;
         logic          level_q;
         logic [DW-1:0] stable_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sync_q     <= '0;
               level_q    <= 1'b0;
               stable_cnt <= '0;
            end else begin
               sync_q <= {sync_q[0], raw[k]};
               if (sync_q[1] == level_q) begin
                  stable_cnt <= '0;
               end else if (tick) begin
                  if (stable_cnt == DW'(DEB_TICKS - 1)) begin
                     level_q    <= sync_q[1];
                     stable_cnt <= '0;
                  end else begin
                     stable_cnt <= stable_cnt + 1'b1;
                  end
               end
            end
         end

         assign clean[k] = level_q;
      end
   endgenerate

endmodule

// File: rtl/band_stepper.sv
module band_stepper (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key,
   output logic [1:0] band
);

   logic key_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_d <= 1'b0;
         band  <= 2'd1;
      end else begin
         key_d <= key;
         if (key && !key_d) begin
            band <= (band == 2'd3) ? 2'd1 : band + 2'd1;
         end
      end
   end

endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             restart,
   input  logic [CNT_W-1:0] term,
   output logic             wave
);

   logic [CNT_W-1:0] half_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_cnt <= '0;
         wave     <= 1'b0;
      end else if (!run || restart) begin
         half_cnt <= '0;
         wave     <= 1'b0;
      end else if (tick) begin
         if (half_cnt == term) begin
            half_cnt <= '0;
            wave     <= ~wave;
         end else begin
            half_cnt <= half_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tone_keyboard.sv
module tone_keyboard #(
   parameter int TICK_DIV   = 4,
   parameter int DEB_TICKS  = 50000,
   parameter int TONE_SHIFT = 0,
   parameter int CNT_W      = 15
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [6:0] note_keys,
   input  logic       band_key,
   output logic       buzz,
   output logic [3:0] band_code,
   output logic [3:0] note_code
);

   import tone_kbd_pkg::*;

   localparam int KEYS      = NUM_NOTES + 1;
   localparam int MIN_HALF  = (2542 >> TONE_SHIFT) >> 1;
   localparam int MAX_HALF  = (19080 >> TONE_SHIFT) >> 1;

   generate
      if (MIN_HALF < 2) begin : g_bad_shift
         $error("tone_keyboard: TONE_SHIFT leaves a half period under two ticks");
      end
      if (MAX_HALF > (1 << CNT_W)) begin : g_bad_width
         $error("tone_keyboard: CNT_W too narrow for the largest half period");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("tone_keyboard: TICK_DIV must be at least 1");
      end
   endgenerate

   // Reference tick enable
   logic tick_en;

   generate
      if (TICK_DIV == 1) begin : g_tick_full
         assign tick_en = 1'b1;
      end else begin : g_tick_div
         localparam int TW = $clog2(TICK_DIV);
         logic [TW-1:0] tick_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tick_cnt <= '0;
            end else if (tick_cnt == TW'(TICK_DIV - 1)) begin
               tick_cnt <= '0;
            end else begin
               tick_cnt <= tick_cnt + 1'b1;
            end
         end
         assign tick_en = (tick_cnt == TW'(TICK_DIV - 1));
      end
   endgenerate

   // Key conditioning
   logic [KEYS-1:0] keys_clean;

   key_conditioner #(
      .NUM_KEYS  (KEYS),
      .DEB_TICKS (DEB_TICKS)
   ) u_keys (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_en),
      .raw   ({band_key, note_keys}),
      .clean (keys_clean)
   );

   logic [NUM_NOTES-1:0] notes_clean;
   assign notes_clean = keys_clean[NUM_NOTES-1:0];

   // Band selection
   logic [1:0] band;

   band_stepper u_band (
      .clk   (clk),
      .rst_n (rst_n),
      .key   (keys_clean[KEYS-1]),
      .band  (band)
   );

   // Note decode
   logic       note_valid;
   logic [2:0] note_idx;

   always_comb begin
      note_idx = '0;
      for (int i = 0; i < NUM_NOTES; i++) begin
         if (notes_clean[i]) note_idx = 3'(i);
      end
   end

   assign note_valid = $onehot(notes_clean);

   // Divisor lookup and change detection
   logic [31:0]      full_div;
   logic [CNT_W-1:0] term;
   logic [4:0]       sel, sel_q;
   logic             restart;

   always_comb begin
      full_div = full_period(32'(band - 2'd1), 32'(note_idx));
      term     = CNT_W'(((full_div >> TONE_SHIFT) >> 1) - 32'd1);
   end

   assign sel     = {band, note_idx};
   assign restart = note_valid && (sel != sel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= sel;
   end

   tone_divider #(
      .CNT_W (CNT_W)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_en),
      .run     (note_valid),
      .restart (restart),
      .term    (term),
      .wave    (buzz)
   );

   assign band_code = {2'b00, band};
   assign note_code = note_valid ? (4'(note_idx) + 4'd1) : 4'd0;

endmodule

// File: rtl/tone_keyboard_chk.sv
module tone_keyboard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       buzz,
   input logic [3:0] band_code,
   input logic [3:0] note_code
);

   // R2: band digit stays within 1..3
   p_band_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (band_code == 4'd1) || (band_code == 4'd2) || (band_code == 4'd3));

   // R3: any band change is exactly one step of the 1-2-3 cycle
   p_band_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (band_code != $past(band_code)) |->
         (band_code == (($past(band_code) == 4'd3) ? 4'd1 : $past(band_code) + 4'd1)));

   // R5: note digit never exceeds 7
   p_note_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      note_code <= 4'd7);

   // R6: no valid note means the buzzer is low on the following clock
   p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (note_code == 4'd0) |=> !buzz);

   // R7: the buzzer only rises on a reference tick
   p_rise_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buzz) |-> $past(tick));

   // R9: a note change forces the buzzer low on the next clock
   p_restart_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((note_code != $past(note_code)) && (note_code != 4'd0)) |=> !buzz);

endmodule

bind tone_keyboard tone_keyboard_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick_en),
   .buzz      (buzz),
   .band_code (band_code),
   .note_code (note_code)
);

// File: tb/tone_keyboard_tb_top.sv
module tone_keyboard_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int TDIV       = 4;
   localparam int DEB        = 4;
   localparam int SHIFT      = 6;
   localparam int SETTLE     = 40;
   localparam int WD_LIMIT   = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] note_keys = '0;
   logic       band_key = 1'b0;
   logic       buzz;
   logic [3:0] band_code;
   logic [3:0] note_code;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   int divs [21] = '{19080, 17006, 15150, 14326, 12756, 11360, 10120,
                     9560, 8516, 7586, 7160, 6376, 5680, 5060,
                     4776, 4256, 3790, 3580, 3190, 2842, 2542};

   tone_keyboard #(
      .TICK_DIV   (TDIV),
      .DEB_TICKS  (DEB),
      .TONE_SHIFT (SHIFT),
      .CNT_W      (15)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .note_keys (note_keys),
      .band_key  (band_key),
      .buzz      (buzz),
      .band_code (band_code),
      .note_code (note_code)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic press_band();
      band_key = 1'b1;
      wait_clk(SETTLE);
      band_key = 1'b0;
      wait_clk(SETTLE);
   endtask

   task automatic measure(output int hi, output int lo);
      int n;
      hi = 0;
      lo = 0;
      n = 0;
      while (buzz !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
      n = 0;
      while (buzz !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
      while (buzz === 1'b1 && hi < 5000) begin @(negedge clk); hi++; end
      while (buzz === 1'b0 && lo < 5000) begin @(negedge clk); lo++; end
   endtask

   function automatic int half_clks(input int idx);
      return ((divs[idx] >> SHIFT) >> 1) * TDIV;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // Watchdog
   initial begin
      while (cycles < WD_LIMIT) begin
         @(posedge clk);
         cycles++;
      end
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, WD_LIMIT);
      finish_run();
   end

   initial begin
      int hi, lo, exp, n;
      bit quiet;

      // R1: reset state
      wait_clk(5);
      check(band_code == 4'd1, "R1 band during reset", band_code, 1);
      check(note_code == 4'd0, "R1 note during reset", note_code, 0);
      check(buzz == 1'b0, "R1 buzz during reset", buzz, 0);
      rst_n = 1'b1;
      wait_clk(3);
      check(band_code == 4'd1 && note_code == 4'd0 && buzz == 1'b0,
            "R1 state after release", band_code, 1);

      // R4: short glitches are filtered out
      band_key = 1'b1;
      wait_clk(6);
      band_key = 1'b0;
      wait_clk(SETTLE);
      check(band_code == 4'd1, "R4 band glitch ignored", band_code, 1);
      note_keys = 7'b0000100;
      wait_clk(6);
      note_keys = '0;
      quiet = 1'b1;
      for (int i = 0; i < SETTLE; i++) begin
         @(negedge clk);
         if (note_code != 4'd0 || buzz != 1'b0) quiet = 1'b0;
      end
      check(quiet, "R4 note glitch ignored", note_code, 0);

      // Sweep all 21 tones
      for (int b = 1; b <= 3; b++) begin
         if (b > 1) press_band();
         check(band_code == 4'(b), "R3 band step", band_code, b);
         check(band_code >= 4'd1 && band_code <= 4'd3, "R2 band range", band_code, b);
         for (int n2 = 1; n2 <= 7; n2++) begin
            note_keys = 7'(1 << (n2 - 1));
            wait_clk(SETTLE);
            check(note_code == 4'(n2), "R5 note code", note_code, n2);
            measure(hi, lo);
            exp = half_clks((b - 1) * 7 + (n2 - 1));
            check(hi == exp, "R7 high phase", hi, exp);
            check(lo == exp, "R8 low phase", lo, exp);
            note_keys = '0;
            wait_clk(SETTLE);
            quiet = 1'b1;
            for (int i = 0; i < 20; i++) begin
               @(negedge clk);
               if (buzz != 1'b0 || note_code != 4'd0) quiet = 1'b0;
            end
            check(quiet, "R6 released keys silent", note_code, 0);
         end
      end

      // R3: wrap from 3 back to 1, holding the key advances once
      press_band();
      check(band_code == 4'd1, "R3 band wrap", band_code, 1);
      band_key = 1'b1;
      wait_clk(4 * SETTLE);
      check(band_code == 4'd2, "R3 held key steps once", band_code, 2);
      band_key = 1'b0;
      wait_clk(SETTLE);
      check(band_code == 4'd2, "R3 release has no effect", band_code, 2);

      // R6: two keys at once
      note_keys = 7'b0000101;
      wait_clk(SETTLE);
      quiet = 1'b1;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (buzz != 1'b0 || note_code != 4'd0) quiet = 1'b0;
      end
      check(quiet, "R6 two keys silent", note_code, 0);
      note_keys = '0;
      wait_clk(SETTLE);

      // R9: switch note while the buzzer is high
      note_keys = 7'b0000001;
      wait_clk(SETTLE);
      n = 0;
      while (buzz !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
      note_keys = 7'b0000010;
      n = 0;
      while (note_code != 4'd2 && n < 200) begin @(negedge clk); n++; end
      @(negedge clk);
      check(buzz == 1'b0, "R9 restart low", buzz, 0);
      measure(hi, lo);
      exp = half_clks(7 + 1);
      check(hi == exp, "R9 new tone high phase", hi, exp);

      // R9: band change while a note is held
      press_band();
      check(band_code == 4'd3, "R9 band moved", band_code, 3);
      measure(hi, lo);
      exp = half_clks(14 + 1);
      check(lo == exp, "R9 new band low phase", lo, exp);
      note_keys = '0;
      wait_clk(SETTLE);

      finish_run();
   end

endmodule